// File: doc/BRIEF.md
# NAND Page Hamming ECC Accumulator

This block sits inline on the byte stream of a NAND flash controller and builds, as the page goes by, the Hamming-style parity that the controller keeps beside each page. Every byte presented with the valid strobe appears unchanged on the pass-through outputs in the same cycle. The same byte also updates three registers on the clock edge:

- A 6-bit column parity accumulator.
- Two 16-bit line parity words.
- A 16-bit byte index.

The column parity comes from XORing subsets of the byte's bits. The line parity words change only for bytes with an odd number of ones. When they change, one word takes in the current byte index and the other takes in the index's bitwise complement.

A synchronous clear starts a new page. The asynchronous active-low reset sets all state to zero at once. The design keeps that reset active internally until two clock edges after it is released. Comparing stored and recomputed parity is not part of this block, and neither is correcting bits.

Top module: `nand_ecc_accum`

## Requirements
- R1: `byte_o` equals `byte_i` and `byte_vld_o` equals `byte_vld_i` in the same cycle, with no register in between.
- R2: For each accepted byte d, a 6-bit code is XORed into `col_par_o`. Its bits are formed as follows:
  - bit 0 = d0^d2^d4^d6
  - bit 1 = d1^d3^d5^d7
  - bit 2 = d0^d1^d4^d5
  - bit 3 = d2^d3^d6^d7
  - bit 4 = d0^d1^d2^d3
  - bit 5 = d4^d5^d6^d7

  Examples: 0x01 gives 0x15, 0x02 gives 0x16, 0x03 gives 0x03, 0x00 gives 0x00.
- R3: An accepted byte with an odd number of ones changes the line parity words. An accepted byte with an even number of ones leaves both words unchanged.
- R4: On an accepted odd byte, `lpar_inv_o` is XORed with the bitwise inverse of the byte index held before that byte, and `lpar_idx_o` is XORed with that index itself.
- R5: `byte_cnt_o` increases by one after every accepted byte, whatever its parity, and wraps from 0xFFFF to 0x0000.
- R6: A clock edge with `clear_i` high sets all four accumulator outputs to zero. This holds even when `byte_vld_i` is also high, and that byte is not accumulated.
- R7: Driving `rst_n` low sets all accumulator outputs to zero without waiting for a clock edge. Bytes are accepted again from the third rising edge after `rst_n` goes high.
- R8: A cycle with `byte_vld_i` low changes no accumulator output, whatever `byte_i` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous page restart |
| byte_vld_i | input | 1 | Input byte valid |
| byte_i | input | 8 | Input data byte |
| byte_vld_o | output | 1 | Pass-through valid |
| byte_o | output | 8 | Pass-through data byte |
| col_par_o | output | 6 | Column parity accumulator |
| lpar_inv_o | output | 16 | Line parity word fed by the inverted byte index |
| lpar_idx_o | output | 16 | Line parity word fed by the byte index |
| byte_cnt_o | output | 16 | Running byte index within the page |

## Verification
Each of the 256 byte values is sent alone into a freshly cleared page. The column output must show exactly that byte's code, and the line words must show the parity bit, which separates even bytes from odd ones. Pseudo-random 256-byte and 512-byte pages are checked against a bench model, so an index error in either line word shows up. A run of 65,537 zero bytes, followed by one odd byte, exercises counter wrap and the complement rule at a known index. Directed patterns cover the remaining behaviours:
- clear in the same cycle as valid;
- idle cycles that carry changing data;
- a mid-page asynchronous reset.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int unsigned ECC_DATA_W  = 8;
  localparam int unsigned ECC_CNT_W   = 16;
  localparam int unsigned ECC_SYNC_ST = 2;
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ecc_byte_code.sv
module ecc_byte_code #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W),
  localparam int unsigned COL_W = 2 * IDX_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [COL_W-1:0]  col_code,
  output logic              odd
);
  always_comb begin
    col_code = '0;
    for (int k = 0; k < IDX_W; k++) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (((b >> k) & 1) != 0) col_code[2*k+1] = col_code[2*k+1] ^ data[b];
        else                     col_code[2*k]   = col_code[2*k]   ^ data[b];
      end
    end
    odd = ^data;
  end

  always_comb begin
    AST_PARITY_SPLIT: assert ((col_code[0] ^ col_code[1]) == odd); // R3
  end
endmodule

// File: rtl/ecc_line_accum.sv
module ecc_line_accum #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             odd,
  output logic [CNT_W-1:0] lpar_inv,
  output logic [CNT_W-1:0] lpar_idx,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] inv_q, inv_d, idx_q, idx_d, cnt_q, cnt_d;
  logic             en;

  assign en = clear | step;

  always_comb begin
    inv_d = inv_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    if (clear) begin
      inv_d = '0;
      idx_d = '0;
      cnt_d = '0;
    end else if (step) begin
      if (odd) begin
        inv_d = inv_q ^ ~cnt_q;
        idx_d = idx_q ^ cnt_q;
      end
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q <= '0;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      inv_q <= inv_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign lpar_inv = inv_q;
  assign lpar_idx = idx_q;
  assign cnt      = cnt_q;

  AST_EVEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !odd) |=> ($stable(lpar_inv) && $stable(lpar_idx))); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> (cnt == $past(cnt) + ONE)); // R5
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0 && lpar_inv == '0 && lpar_idx == '0)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> ($stable(cnt) && $stable(lpar_inv) && $stable(lpar_idx))); // R8
endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int unsigned DATA_W = ECC_DATA_W,
  parameter int unsigned CNT_W  = ECC_CNT_W,
  localparam int unsigned COL_W = 2 * $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic [COL_W-1:0]  col_par_o,
  output logic [CNT_W-1:0]  lpar_inv_o,
  output logic [CNT_W-1:0]  lpar_idx_o,
  output logic [CNT_W-1:0]  byte_cnt_o
);
  logic             rst_sync_n;
  logic [COL_W-1:0] code_col;
  logic             code_odd;
  logic [COL_W-1:0] col_q, col_d;
  logic             step;

  ecc_rst_sync #(.STAGES(ECC_SYNC_ST)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ecc_byte_code #(.DATA_W(DATA_W)) u_code (
    .data(byte_i), .col_code(code_col), .odd(code_odd)
  );

  assign step       = byte_vld_i & ~clear_i;
  assign byte_vld_o = byte_vld_i;
  assign byte_o     = byte_i;

  always_comb begin
    col_d = col_q;
    if (clear_i)   col_d = '0;
    else if (step) col_d = col_q ^ code_col;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)             col_q <= '0;
    else if (clear_i | step)     col_q <= col_d;
  end

  assign col_par_o = col_q;

  ecc_line_accum #(.CNT_W(CNT_W)) u_line (
    .clk(clk), .rst_n(rst_sync_n), .clear(clear_i), .step(byte_vld_i),
    .odd(code_odd), .lpar_inv(lpar_inv_o), .lpar_idx(lpar_idx_o), .cnt(byte_cnt_o)
  );

  AST_LINE_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((lpar_inv_o ^ lpar_idx_o) == '0) || ((lpar_inv_o ^ lpar_idx_o) == '1)); // R4
  AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clear_i |=> (col_par_o == '0)); // R6
  AST_COL_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!byte_vld_i && !clear_i) |=> $stable(col_par_o)); // R8
endmodule

// File: tb/tb_nand_ecc_accum.sv
module tb_nand_ecc_accum;
  logic        clk = 1'b0;
  logic        rst_n, clear_i, byte_vld_i;
  logic [7:0]  byte_i;
  logic        byte_vld_o;
  logic [7:0]  byte_o;
  logic [5:0]  col_par_o;
  logic [15:0] lpar_inv_o, lpar_idx_o, byte_cnt_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [5:0]  m_col;
  logic [15:0] m_inv, m_idx, m_cnt;

  // {data, expected 7-bit code with parity in bit 6}
  localparam logic [15:0] VEC [21] = '{
    16'h00_00, 16'h01_55, 16'h02_56, 16'h03_03, 16'h04_59, 16'h05_0c,
    16'h06_0f, 16'h07_5a, 16'h08_5a, 16'h09_0f, 16'h0a_0c, 16'h0b_59,
    16'h0c_03, 16'h0d_56, 16'h0e_55, 16'h0f_00, 16'h10_65, 16'h40_69,
    16'h80_6a, 16'hf0_00, 16'hff_00
  };

  always #4 clk = ~clk;

  nand_ecc_accum dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .byte_vld_o(byte_vld_o), .byte_o(byte_o),
    .col_par_o(col_par_o), .lpar_inv_o(lpar_inv_o), .lpar_idx_o(lpar_idx_o),
    .byte_cnt_o(byte_cnt_o)
  );

  function automatic logic [6:0] ref_code(input logic [7:0] d);
    logic [6:0] c = '0;
    for (int b = 0; b < 8; b++) begin
      if (d[b]) begin
        c[b[0] ? 1 : 0] ^= 1'b1;
        c[b[1] ? 3 : 2] ^= 1'b1;
        c[b[2] ? 5 : 4] ^= 1'b1;
        c[6]            ^= 1'b1;
      end
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_col = '0; m_inv = '0; m_idx = '0; m_cnt = '0;
  endtask

  task automatic drive(input logic v, input logic c, input logic [7:0] d);
    @(negedge clk);
    byte_vld_i = v; clear_i = c; byte_i = d;
    if (c) model_clear();
    else if (v) begin
      logic [6:0] k = ref_code(d);
      m_col ^= k[5:0];
      if (k[6]) begin m_inv ^= ~m_cnt; m_idx ^= m_cnt; end
      m_cnt++;
    end
  endtask

  task automatic check_model(input string req);
    chk(req, {26'd0, col_par_o}, {26'd0, m_col});
    chk(req, {16'd0, lpar_inv_o}, {16'd0, m_inv});
    chk(req, {16'd0, lpar_idx_o}, {16'd0, m_idx});
    chk(req, {16'd0, byte_cnt_o}, {16'd0, m_cnt});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1ace_b00c;
    rst_n = 1'b0; clear_i = 1'b0; byte_vld_i = 1'b0; byte_i = 8'h00;
    model_clear();
    #1;
    chk("R7 reset col", {26'd0, col_par_o}, 32'd0);
    chk("R7 reset cnt", {16'd0, byte_cnt_o}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 table vectors
    foreach (VEC[i]) begin
      drive(1'b0, 1'b1, 8'h00);
      drive(1'b1, 1'b0, VEC[i][15:8]);
      #1;
      chk("R1 pass data", {24'd0, byte_o}, {24'd0, VEC[i][15:8]});
      chk("R1 pass vld", {31'd0, byte_vld_o}, 32'd1);
      drive(1'b0, 1'b0, 8'h00);
      chk("R2 col code", {26'd0, col_par_o}, {26'd0, VEC[i][5:0]});
      chk("R3 parity", {16'd0, lpar_inv_o}, VEC[i][6] ? 32'hffff : 32'h0);
      chk("R5 count one", {16'd0, byte_cnt_o}, 32'd1);
    end

    // R2 R3 all 256 byte values
    for (int v = 0; v < 256; v++) begin
      drive(1'b0, 1'b1, 8'h00);
      drive(1'b1, 1'b0, v[7:0]);
      drive(1'b0, 1'b0, 8'h00);
      check_model("R2 R3 sweep");
    end

    // R4 full pages of 256 and 512 bytes
    for (int p = 0; p < 2; p++) begin
      drive(1'b0, 1'b1, 8'h00);
      for (int n = 0; n < (p == 0 ? 256 : 512); n++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        drive(1'b1, 1'b0, lfsr[7:0]);
      end
      drive(1'b0, 1'b0, 8'h00);
      check_model("R4 page");
    end

    // R8 idle cycles with changing data
    drive(1'b0, 1'b0, 8'h01);
    drive(1'b0, 1'b0, 8'h7f);
    drive(1'b0, 1'b0, 8'h00);
    check_model("R8 idle");

    // R6 clear wins over valid
    drive(1'b1, 1'b1, 8'h01);
    drive(1'b0, 1'b0, 8'h00);
    chk("R6 clear col", {26'd0, col_par_o}, 32'd0);
    chk("R6 clear inv", {16'd0, lpar_inv_o}, 32'd0);
    chk("R6 clear cnt", {16'd0, byte_cnt_o}, 32'd0);

    // R5 wrap, then R4 at known index 1
    for (int n = 0; n < 65537; n++) drive(1'b1, 1'b0, 8'h00);
    drive(1'b0, 1'b0, 8'h00);
    chk("R5 wrap", {16'd0, byte_cnt_o}, 32'd1);
    drive(1'b1, 1'b0, 8'h01);
    drive(1'b0, 1'b0, 8'h00);
    chk("R4 inv word", {16'd0, lpar_inv_o}, 32'hfffe);
    chk("R4 idx word", {16'd0, lpar_idx_o}, 32'h0001);

    // R7 asynchronous reset mid-page
    drive(1'b1, 1'b0, 8'h07);
    #1 rst_n = 1'b0;
    #1;
    chk("R7 async cnt", {16'd0, byte_cnt_o}, 32'd0);
    chk("R7 async inv", {16'd0, lpar_inv_o}, 32'd0);
    chk("R7 async col", {26'd0, col_par_o}, 32'd0);
    byte_vld_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    // held in reset through the first two edges after release
    byte_vld_i = 1'b1; byte_i = 8'h01;
    @(negedge clk);
    @(negedge clk);
    chk("R7 sync hold", {16'd0, byte_cnt_o}, 32'd0);
    @(negedge clk);
    byte_vld_i = 1'b0;
    chk("R7 accept again", {16'd0, byte_cnt_o}, 32'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule